// File: doc/BRIEF.md
# Two-Task Banked Address Translator

This block sits between an 8-bit CPU's 16-bit logical address bus and a 512 KB RAM array. The RAM is treated as 64 blocks of 8 KB. The CPU's 64 KB view is cut into eight 8 KB windows, and each window is pointed at any physical block through a 6-bit map register. Sixteen map registers exist, in two sets of eight called tasks. A single control bit picks the set in use. An operating system can therefore keep one map for itself and one for a user process, and swap between them with one register write.

Two regions bypass the maps. The top 256 bytes of the logical space (FF00 to FFFF) are always the I/O page. For them the block raises an I/O flag and drives no RAM address. When the vector-page option is on, the 256 bytes just below (FE00 to FEFF) always land on the same physical page at the very top of RAM, whatever task or map is selected. With translation switched off, the CPU sees the top 64 KB of RAM as a flat window.

Configuration uses a small synchronous write port with a combinational readback. Translation is purely combinational, so a new logical address produces its physical address in the same cycle.

Each cycle the address path takes exactly one route. The routes in priority order are:
1. `SRC_IO`: I/O page.
2. `SRC_VECTOR`: forced vector page.
3. `SRC_MAP`: mapped through a register.
4. `SRC_DIRECT`: translation off.

The route is chosen from the current address and control state alone. There is no sequential state beyond the registers.

Top module: `mmu_top`

## Requirements
- R1: The block holds sixteen 6-bit map registers at configuration addresses 0 to 15. The register at address `t*8 + s` serves window `s` of task `t`.
- R2: With translation enabled (control bit 1 set), `phys_addr[18:13]` equals the map register of the active task selected by `cpu_laddr[15:13]`, and `phys_addr[12:0]` equals `cpu_laddr[12:0]`. For example, task 0 with register 0 holding 0x1A translates logical 0x1001 to physical 0x35001.
- R3: Control bit 0 selects the active task: 0 uses registers 0 to 7 and 1 uses registers 8 to 15.
- R4: For logical addresses 0xFF00 to 0xFFFF, `io_sel` is 1 and `phys_addr` is 0, whatever the task, enable or map contents. For every other address `io_sel` is 0.
- R5: With control bit 2 set, logical 0xFE00 to 0xFEFF translates to 0x7FE00 plus `cpu_laddr[7:0]`, ignoring the maps and the enable bit. Address 0xFDFF still uses window 7.
- R6: With control bit 1 clear, a non-I/O address outside the forced vector page translates to `0x70000 + cpu_laddr`.
- R7: After reset, all map registers read 0 and the control register reads 0. Translation is therefore off, task 0 is active and the vector page is off.
- R8: Readback at address 0 to 15 returns `{2'b00, map}`. Address 16 returns `{5'b0, vector, enable, task}`. Addresses 17 to 31 read 0, and writes to them change nothing.
- R9: A write takes effect at the rising clock edge that samples `cfg_we`. Readback and translation show the new value from the following cycle, not in the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address (0-15 maps, 16 control) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Combinational readback of the addressed register |
| cpu_laddr | input | 16 | CPU logical address |
| phys_addr | output | 19 | Translated physical RAM address |
| io_sel | output | 1 | High when the logical address is in the I/O page |

## Verification
The assertions assume that `cfg_addr`, `cfg_wdata`, `cfg_we` and `cpu_laddr` are always known values that change only away from the rising edge. The write-to-readback property also assumes that a register which has just been written is still being addressed in the next cycle before its value is compared. The bench drives every input from reset onward with defined values, always at the falling edge. A per-cycle behavioural model predicts the translation and readback from the same stimulus, mixing directed sequences with seeded random cycles that keep to these assumptions.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    // Control register bit positions (R3, R6, R5)
    localparam int CTL_TASK_BIT = 0;
    localparam int CTL_EN_BIT   = 1;
    localparam int CTL_VEC_BIT  = 2;
    localparam int CTL_W        = 3;

    typedef struct packed {
        logic vec_en;
        logic mmu_en;
        logic task_sel;
    } ctl_t;

    // Translation route, priority highest first: IO, VECTOR, MAP, DIRECT
    typedef enum logic [1:0] {
        SRC_DIRECT = 2'd0,
        SRC_MAP    = 2'd1,
        SRC_VECTOR = 2'd2,
        SRC_IO     = 2'd3
    } xsrc_e;

endpackage

// File: rtl/mmu_regfile.sv
module mmu_regfile
    import mmu_pkg::*;
#(
    parameter int BLK_W = 6,
    parameter int NREG  = 16,
    parameter int AW    = 5,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              addr,
    input  logic [DW-1:0]              wdata,
    output logic [DW-1:0]              rdata,
    output logic [NREG-1:0][BLK_W-1:0] map_arr,
    output ctl_t                       ctl
);
    localparam int IDX_W = $clog2(NREG);
    localparam logic [AW-1:0] CTRL_ADDR = AW'(NREG);

    logic in_map_range;
    logic unused_wdata_hi;

    assign in_map_range    = (addr < CTRL_ADDR);
    assign unused_wdata_hi = ^wdata[DW-1:BLK_W];

    // One 6-bit register per map slot (R1, R7)
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_map
            logic [BLK_W-1:0] slot_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_q <= '0;
                end else if (we && (addr == AW'(g))) begin
                    slot_q <= wdata[BLK_W-1:0];
                end
            end
            assign map_arr[g] = slot_q;
        end
    endgenerate

    // Control register (R3, R5, R6, R7)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (we && (addr == CTRL_ADDR)) begin
            ctl.task_sel <= wdata[CTL_TASK_BIT];
            ctl.mmu_en   <= wdata[CTL_EN_BIT];
            ctl.vec_en   <= wdata[CTL_VEC_BIT];
        end
    end

    // Readback (R8)
    always_comb begin
        rdata = '0;
        if (in_map_range) begin
            rdata = DW'(map_arr[addr[IDX_W-1:0]]);
        end else if (addr == CTRL_ADDR) begin
            rdata = DW'({ctl.vec_en, ctl.mmu_en, ctl.task_sel});
        end
    end

endmodule

// File: rtl/mmu_route.sv
module mmu_route
    import mmu_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] page,
    input  logic              mmu_en,
    input  logic              vec_en,
    output xsrc_e             src
);
    localparam logic [PAGE_W-1:0] IO_PAGE  = '1;
    localparam logic [PAGE_W-1:0] VEC_PAGE = IO_PAGE - PAGE_W'(1);

    // Priority: I/O page, forced vector page, mapped, direct (R4, R5, R2, R6)
    always_comb begin
        if (page == IO_PAGE) begin
            src = SRC_IO;
        end else if (vec_en && (page == VEC_PAGE)) begin
            src = SRC_VECTOR;
        end else if (mmu_en) begin
            src = SRC_MAP;
        end else begin
            src = SRC_DIRECT;
        end
    end

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import mmu_pkg::*;
#(
    parameter int LA_W   = 16,
    parameter int BLK_W  = 6,
    parameter int SLOT_W = 3,
    parameter int PAGE_W = 8
) (
    input  xsrc_e                              src,
    input  logic [BLK_W-1:0]                   blk,
    input  logic [LA_W-1:0]                    laddr,
    output logic [BLK_W+LA_W-SLOT_W-1:0]       phys,
    output logic                               io
);
    localparam int OFF_W = LA_W - SLOT_W;
    localparam int PA_W  = BLK_W + OFF_W;

    always_comb begin
        phys = '0;
        io   = 1'b0;
        unique case (src)
            SRC_IO: begin
                phys = '0;
                io   = 1'b1;
            end
            SRC_VECTOR: begin
                phys = {{(PA_W-PAGE_W-1){1'b1}}, 1'b0, laddr[PAGE_W-1:0]};
            end
            SRC_MAP: begin
                phys = {blk, laddr[OFF_W-1:0]};
            end
            SRC_DIRECT: begin
                phys = {{(PA_W-LA_W){1'b1}}, laddr};
            end
            default: begin
                phys = '0;
                io   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mmu_top.sv
module mmu_top
    import mmu_pkg::*;
#(
    parameter int LA_W   = 16,
    parameter int BLK_W  = 6,
    parameter int SLOT_W = 3,
    parameter int NTASK  = 2,
    parameter int AW     = 5,
    parameter int DW     = 8,
    parameter int PAGE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [AW-1:0]                 cfg_addr,
    input  logic [DW-1:0]                 cfg_wdata,
    output logic [DW-1:0]                 cfg_rdata,
    input  logic [LA_W-1:0]               cpu_laddr,
    output logic [BLK_W+LA_W-SLOT_W-1:0]  phys_addr,
    output logic                          io_sel
);
    localparam int NSLOT  = 1 << SLOT_W;
    localparam int NREG   = NSLOT * NTASK;
    localparam int TASK_W = (NTASK > 1) ? $clog2(NTASK) : 1;
    localparam int IDX_W  = $clog2(NREG);

    logic [NREG-1:0][BLK_W-1:0] map_arr;
    ctl_t                       ctl;
    xsrc_e                      src;
    logic [IDX_W-1:0]           map_idx;
    logic [BLK_W-1:0]           blk_sel;
    logic                       ctl_vec;

    mmu_regfile #(
        .BLK_W (BLK_W),
        .NREG  (NREG),
        .AW    (AW),
        .DW    (DW)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .map_arr (map_arr),
        .ctl     (ctl)
    );

    // Register index = task * NSLOT + window (R1, R3)
    assign map_idx = IDX_W'({TASK_W'(ctl.task_sel), cpu_laddr[LA_W-1 -: SLOT_W]});
    assign blk_sel = map_arr[map_idx];
    assign ctl_vec = ctl.vec_en;

    mmu_route #(
        .PAGE_W (PAGE_W)
    ) route_i (
        .page   (cpu_laddr[LA_W-1 -: PAGE_W]),
        .mmu_en (ctl.mmu_en),
        .vec_en (ctl.vec_en),
        .src    (src)
    );

    mmu_xlate #(
        .LA_W   (LA_W),
        .BLK_W  (BLK_W),
        .SLOT_W (SLOT_W),
        .PAGE_W (PAGE_W)
    ) xlate_i (
        .src   (src),
        .blk   (blk_sel),
        .laddr (cpu_laddr),
        .phys  (phys_addr),
        .io    (io_sel)
    );

endmodule

// File: rtl/mmu_chk.sv
module mmu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [4:0]  cfg_addr,
    input logic [7:0]  cfg_wdata,
    input logic [7:0]  cfg_rdata,
    input logic [15:0] cpu_laddr,
    input logic [18:0] phys_addr,
    input logic        io_sel,
    input logic        vec_en
);

    p_io_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_laddr[15:8] == 8'hFF) |-> (io_sel && (phys_addr == 19'h0)));

    p_not_io_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_laddr[15:8] != 8'hFF) |-> !io_sel);

    p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_laddr[15:9] != 7'h7F) |-> (phys_addr[12:0] == cpu_laddr[12:0]));

    p_vector_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_en && (cpu_laddr[15:8] == 8'hFE)) |->
            (phys_addr == (19'h7FE00 | {11'h0, cpu_laddr[7:0]})));

    p_write_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_addr < 5'd16)) |=>
            ((cfg_addr != $past(cfg_addr)) ||
             (cfg_rdata == {2'b00, $past(cfg_wdata[5:0])})));

    p_hole_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr > 5'd16) |-> (cfg_rdata == 8'h00));

    p_map_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr < 5'd16) |-> (cfg_rdata[7:6] == 2'b00));

endmodule

bind mmu_top mmu_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cpu_laddr (cpu_laddr),
    .phys_addr (phys_addr),
    .io_sel    (io_sel),
    .vec_en    (ctl_vec)
);

// File: tb/mmu_top_tb_top.sv
`timescale 1ns/1ps
module mmu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [15:0] cpu_laddr = '0;
    logic [18:0] phys_addr;
    logic        io_sel;

    int checks = 0;
    int errors = 0;

    // Reference model state
    int m_map [16];
    bit m_task, m_en, m_vec;

    always #2 clk = ~clk;

    mmu_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cpu_laddr (cpu_laddr),
        .phys_addr (phys_addr),
        .io_sel    (io_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h laddr=%h cfg_addr=%0d t=%0t",
                     tag, act, exp, cpu_laddr, cfg_addr, $time);
        end
    endtask

    task automatic compare(input string tag);
        int exp_phys, exp_io, exp_rd, la;
        string t_addr, t_rd;
        la = int'(cpu_laddr);
        if (la >= 'hFF00) begin
            exp_phys = 0; exp_io = 1; t_addr = "R4";
        end else if (m_vec && ((la >> 8) == 'hFE)) begin
            exp_phys = 'h7FE00 + (la & 'hFF); exp_io = 0; t_addr = "R5";
        end else if (m_en) begin
            exp_phys = (m_map[(m_task ? 8 : 0) + (la >> 13)] << 13) | (la & 'h1FFF);
            exp_io = 0; t_addr = m_task ? "R3" : "R2";
        end else begin
            exp_phys = 'h70000 | la; exp_io = 0; t_addr = "R6";
        end
        if (cfg_addr < 16)       exp_rd = m_map[cfg_addr];
        else if (cfg_addr == 16) exp_rd = (int'(m_vec) << 2) | (int'(m_en) << 1) | int'(m_task);
        else                     exp_rd = 0;
        t_rd = "R8";
        if (tag != "") begin t_addr = tag; t_rd = tag; end
        chk(t_addr, int'(phys_addr), exp_phys);
        chk(t_addr, int'(io_sel), exp_io);
        chk(t_rd, int'(cfg_rdata), exp_rd);
    endtask

    // R9: model changes only at the sampling edge
    task automatic step(input bit we, input int a, input int d, input int la, input string tag);
        cfg_we = we; cfg_addr = 5'(a); cfg_wdata = 8'(d); cpu_laddr = 16'(la);
        #1;
        compare(tag);
        @(posedge clk);
        if (we) begin
            if (a < 16) m_map[a] = d & 'h3F;
            else if (a == 16) begin
                m_task = d[0]; m_en = d[1]; m_vec = d[2];
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        foreach (m_map[i]) m_map[i] = 0;
        m_task = 0; m_en = 0; m_vec = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state of every register, translation off (R6 flat window)
        for (int a = 0; a <= 16; a++) step(0, a, 0, 'h1234 + a * 'h0800, "R7");
        step(0, 0, 0, 'h0000, "R6");
        step(0, 0, 0, 'hFEFF, "R6");

        // R9: write map 0, readback unchanged in the write cycle, new after
        step(1, 0, 'h1A, 'h1001, "R9");
        step(0, 0, 0, 'h1001, "R9");
        // R2: enable translation, example 0x1001 -> 0x35001
        step(1, 16, 'h02, 'h1001, "");
        step(0, 16, 0, 'h1001, "R2");
        chk("R2", int'(phys_addr), 'h35001);

        // R1 / R3: load task 1 window 0 and window 7, switch task
        step(1, 8, 'h05, 'h1001, "R1");
        step(1, 15, 'h2C, 'hE123, "R1");
        step(1, 16, 'h03, 'h1001, "R3");
        step(0, 16, 0, 'h1001, "R3");
        chk("R3", int'(phys_addr), 'h0B001);
        step(0, 15, 0, 'hFDFF, "R3");
        chk("R3", int'(phys_addr), ('h2C << 13) | 'h1DFF);

        // R8: upper two bits of a map write are dropped
        step(1, 3, 'hFF, 'h6000, "R8");
        step(0, 3, 0, 'h6000, "R8");

        // R4: I/O page under several settings
        step(0, 0, 0, 'hFF00, "R4");
        step(0, 0, 0, 'hFFFF, "R4");
        step(1, 16, 'h00, 'hFF80, "R4");
        step(0, 0, 0, 'hFF80, "R4");

        // R5: forced vector page with translation off and on
        step(1, 16, 'h04, 'hFE00, "R5");
        step(0, 16, 0, 'hFE00, "R5");
        step(0, 16, 0, 'hFE7F, "R5");
        step(1, 16, 'h07, 'hFE7F, "R5");
        step(0, 16, 0, 'hFEFF, "R5");
        step(0, 16, 0, 'hFDFF, "R5");
        step(0, 16, 0, 'hFF00, "R4");

        // R8: writes to unused addresses are ignored
        step(1, 17, 'hFF, 'h4000, "R8");
        step(1, 31, 'hFF, 'h4000, "R8");
        for (int a = 0; a < 32; a++) step(0, a, 0, 'h4000, "R8");

        // Random traffic, every cycle compared
        for (int n = 0; n < 3000; n++) begin
            int a, d, la;
            bit we;
            we = ($urandom % 4) == 0;
            a  = (($urandom % 8) == 0) ? 16 : int'($urandom % 20);
            d  = int'($urandom % 256);
            la = (($urandom % 6) == 0) ? ('hFE00 + int'($urandom % 512)) : int'($urandom % 65536);
            step(we, a, d, la, "");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule